// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block derives a slower clock from a reference by a ratio taken from a fixed menu that includes half-integer steps. It runs on a clock at twice the reference rate, so every half of a reference period is one fast-clock cycle. A ratio is therefore a count of fast cycles, and the divided clock can rise or fall on half-period boundaries of the reference.

The ratio is selected by a code equal to twice the divide value. Codes 3 to 15 give the ratios 1.5 to 7.5 in half steps. Even codes 16 to 32 give the whole ratios 8 to 16. Whole ratios always give an even high/low split. For half ratios the split depends on a build-time frequency-mode parameter. The low-frequency variant widens the high phase by half a fast cycle using a falling-edge stage, which gives an exact 50% duty. The high-frequency variant stays on rising edges only, so the high phase is the floor of half the period. The output stays quiet until the lock input is asserted, and it stops at once when lock is lost.

A strobe marks each rising edge of the divided clock, for logic that has to act once per output period in the fast domain.

Top module: `halfstep_clk_div`

## Requirements
- R1: With a legal code S on `ratio_sel_i`, the divided clock has a period of exactly S fast-clock cycles.
- R2: A code S is legal when 3 <= S <= 15, or when S is even and 16 <= S <= 32. Every other 6-bit value is illegal.
- R3: For an even legal code S, the output is high for S/2 fast cycles and low for S/2 fast cycles.
- R4: With HIGH_FREQ = 0 and an odd legal code S, the output is high for exactly S half-cycles of the fast clock (50% duty). The extra half-cycle is added after a falling fast-clock edge.
- R5: With HIGH_FREQ = 1 and an odd legal code S, the output is high for (S-1)/2 fast cycles and low for the remaining (S+1)/2.
- R6: An illegal code makes the divider run with a period of 4 fast cycles (ratio 2, 50% duty) and drives `sel_err_o` high. `sel_err_o` is low for every legal code.
- R7: While reset is active or `lock_i` is low, `clk_div_o` and `rise_stb_o` are low. The first fast-clock rising edge that samples `lock_i` high starts a high phase.
- R8: When `lock_i` falls, `clk_div_o` goes low without waiting for a clock edge. The phase count restarts, so relocking begins a new, complete period.
- R9: A new code takes effect only at the next rising edge of the divided clock. The period in progress completes at the old ratio.
- R10: `rise_stb_o` is high for exactly one fast cycle per output period: the first fast cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x_i | input | 1 | Fast clock at twice the reference rate |
| rst_i | input | 1 | Asynchronous reset, active high |
| lock_i | input | 1 | Lock qualifier from the feedback loop; the output runs only while it is high |
| ratio_sel_i | input | SEL_W | Divide code, equal to twice the divide ratio |
| clk_div_o | output | 1 | Divided clock |
| rise_stb_o | output | 1 | One-fast-cycle pulse at each rising edge of the divided clock |
| sel_err_o | output | 1 | High while the divide code is illegal |

## Verification
Several properties hold on every clock and are checked by assertions. The phase count stays below the active period. The active ratio changes only at the start of a period. Loss of lock clears the running state on the next edge. The strobe never lasts two cycles. Other behaviour can only be shown by the bench's scenarios, which count half-cycles between strobes on both frequency-mode variants. These include the exact high-phase length in half-cycles, the fallback ratio for illegal codes, the asynchronous drop of the output on lock loss, and the completion of an old period after a ratio change.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

   // Period used when the select code is outside the menu (ratio 2).
   localparam int FALLBACK_TWICE = 4;

   // A code is legal if it is a half step up to the odd limit,
   // or an even code from the odd limit up to the maximum.
   function automatic logic ratio_legal(input int code, input int max_twice,
                                        input int max_odd);
      logic ok;
      ok = 1'b0;
      if (code >= 3 && code <= max_odd)
         ok = 1'b1;
      else if (code > max_odd && code <= max_twice && (code % 2) == 0)
         ok = 1'b1;
      return ok;
   endfunction

endpackage

// File: rtl/hdiv_ratio_decode.sv
`timescale 1ns/1ps
module hdiv_ratio_decode #(
   parameter int SEL_W         = 6,
   parameter int MAX_TWICE     = 32,
   parameter int MAX_ODD_TWICE = 15
) (
   input  logic [SEL_W-1:0] sel_code,
   output logic [SEL_W-1:0] period_twice,
   output logic             code_bad
);
   logic legal;

   always_comb begin
      legal        = hdiv_pkg::ratio_legal(int'(sel_code), MAX_TWICE, MAX_ODD_TWICE);
      period_twice = legal ? sel_code : SEL_W'(hdiv_pkg::FALLBACK_TWICE);
      code_bad     = !legal;
   end

endmodule

// File: rtl/hdiv_phase_gen.sv
`timescale 1ns/1ps
module hdiv_phase_gen #(
   parameter int SEL_W     = 6,
   parameter int MAX_TWICE = 32,
   parameter bit HIGH_FREQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lock,
   input  logic [SEL_W-1:0] period_new,
   output logic             shaped,
   output logic             edge_stb
);
   localparam int CNT_W = $clog2(MAX_TWICE);

   logic [SEL_W-1:0] period_act, period_nxt;
   logic [CNT_W-1:0] ph_cnt, ph_nxt;
   logic             running, wrap, q_pos;

   always_comb begin
      wrap       = running && (ph_cnt == CNT_W'(period_act - 1'b1));
      ph_nxt     = (!running || wrap) ? '0 : ph_cnt + 1'b1;
      period_nxt = (!running || wrap) ? period_new : period_act;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         running    <= 1'b0;
         ph_cnt     <= '0;
         period_act <= SEL_W'(hdiv_pkg::FALLBACK_TWICE);
         q_pos      <= 1'b0;
         edge_stb   <= 1'b0;
      end else if (!lock) begin
         running    <= 1'b0;
         ph_cnt     <= '0;
         period_act <= period_new;
         q_pos      <= 1'b0;
         edge_stb   <= 1'b0;
      end else begin
         running    <= 1'b1;
         ph_cnt     <= ph_nxt;
         period_act <= period_nxt;
         q_pos      <= SEL_W'(ph_nxt) < (period_nxt >> 1);
         edge_stb   <= (ph_nxt == '0);
      end
   end

   generate
      if (HIGH_FREQ) begin : g_floor_duty
         assign shaped = q_pos;
      end else begin : g_balanced_duty
         logic q_neg;
         always_ff @(negedge clk or posedge rst) begin
            if (rst)       q_neg <= 1'b0;
            else if (!lock) q_neg <= 1'b0;
            else           q_neg <= q_pos;
         end
         // Odd periods stretch the high phase by one half-cycle.
         assign shaped = q_pos | (q_neg & period_act[0]);
      end
   endgenerate

   p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
      running |-> (SEL_W'(ph_cnt) < period_act));

   p_period_legal_r2: assert property (@(posedge clk) disable iff (rst)
      running |-> (period_act >= SEL_W'(3) && period_act <= SEL_W'(MAX_TWICE)));

   p_ratio_at_rise_r9: assert property (@(posedge clk) disable iff (rst)
      !$stable(period_act) |-> (ph_cnt == '0));

   p_unlock_clears_r8: assert property (@(posedge clk) disable iff (rst)
      !lock |=> (!running && !q_pos && !edge_stb));

   p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
      edge_stb |=> !edge_stb);

endmodule

// File: rtl/halfstep_clk_div.sv
`timescale 1ns/1ps
module halfstep_clk_div #(
   parameter int SEL_W         = 6,
   parameter int MAX_TWICE     = 32,
   parameter int MAX_ODD_TWICE = 15,
   parameter bit HIGH_FREQ     = 1'b0
) (
   input  logic             clk_2x_i,
   input  logic             rst_i,
   input  logic             lock_i,
   input  logic [SEL_W-1:0] ratio_sel_i,
   output logic             clk_div_o,
   output logic             rise_stb_o,
   output logic             sel_err_o
);
   initial begin
      assert (SEL_W >= $clog2(MAX_TWICE + 1))
         else $error("SEL_W too narrow for MAX_TWICE");
      assert (MAX_ODD_TWICE >= 3 && MAX_ODD_TWICE < MAX_TWICE && (MAX_ODD_TWICE % 2) == 1)
         else $error("MAX_ODD_TWICE must be odd, >= 3 and below MAX_TWICE");
   end

   logic [SEL_W-1:0] period_sel;
   logic             shaped, edge_stb;

   hdiv_ratio_decode #(
      .SEL_W(SEL_W), .MAX_TWICE(MAX_TWICE), .MAX_ODD_TWICE(MAX_ODD_TWICE)
   ) u_decode (
      .sel_code    (ratio_sel_i),
      .period_twice(period_sel),
      .code_bad    (sel_err_o)
   );

   hdiv_phase_gen #(
      .SEL_W(SEL_W), .MAX_TWICE(MAX_TWICE), .HIGH_FREQ(HIGH_FREQ)
   ) u_phase (
      .clk       (clk_2x_i),
      .rst       (rst_i),
      .lock      (lock_i),
      .period_new(period_sel),
      .shaped    (shaped),
      .edge_stb  (edge_stb)
   );

   // Lock gates the outputs combinationally so loss of lock stops them at once.
   assign clk_div_o  = shaped & lock_i;
   assign rise_stb_o = edge_stb & lock_i;

endmodule

// File: tb/test_halfstep_clk_div.sv
`timescale 1ns/1ps
module test_halfstep_clk_div;
   logic       clk  = 1'b0;
   logic       rst  = 1'b1;
   logic       lock = 1'b0;
   logic [5:0] sel  = 6'd4;
   logic       clk_a, stb_a, err_a, clk_b, stb_b, err_b;
   int         n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   halfstep_clk_div i_halfstep_clk_div (
      .clk_2x_i(clk), .rst_i(rst), .lock_i(lock), .ratio_sel_i(sel),
      .clk_div_o(clk_a), .rise_stb_o(stb_a), .sel_err_o(err_a));

   halfstep_clk_div #(.HIGH_FREQ(1'b1)) i_halfstep_clk_div_hf (
      .clk_2x_i(clk), .rst_i(rst), .lock_i(lock), .ratio_sel_i(sel),
      .clk_div_o(clk_b), .rise_stb_o(stb_b), .sel_err_o(err_b));

   // {code, period in fast cycles, HF high half-cycles, error flag}
   localparam int NV = 13;
   localparam int VEC [NV][4] = '{
      '{3, 3, 2, 0},   '{4, 4, 4, 0},   '{5, 5, 4, 0},   '{7, 7, 6, 0},
      '{9, 9, 8, 0},   '{15, 15, 14, 0}, '{16, 16, 16, 0}, '{17, 4, 4, 1},
      '{24, 24, 24, 0}, '{32, 32, 32, 0}, '{2, 4, 4, 1},  '{33, 4, 4, 1},
      '{0, 4, 4, 1}};

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic to_pos();
      @(posedge clk); #1.25;
   endtask

   task automatic wait_stb();
      do to_pos(); while (stb_a !== 1'b1);
   endtask

   // Starts at a strobe sample point; counts half-cycles until the next strobe.
   task automatic measure(output int halves, output int hi_a, output int hi_b,
                          output int stb_h);
      halves = 0; hi_a = 0; hi_b = 0; stb_h = 0;
      while (1) begin
         halves++; hi_a += int'(clk_a); hi_b += int'(clk_b); stb_h += int'(stb_a);
         @(negedge clk); #1.25;
         halves++; hi_a += int'(clk_a); hi_b += int'(clk_b); stb_h += int'(stb_a);
         to_pos();
         if (stb_a === 1'b1) break;
      end
   endtask

   initial begin
      #750000;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int h, ha, hb, hs, seen;
      repeat (3) to_pos();
      chk("R7 reset clk", int'(clk_a | clk_b), 0);
      chk("R7 reset stb", int'(stb_a | stb_b), 0);
      rst = 1'b0;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         to_pos();
         seen += int'(clk_a | clk_b | stb_a | stb_b);
      end
      chk("R7 idle while unlocked", seen, 0);
      lock = 1'b1;
      to_pos();
      chk("R7 first rise clk", int'(clk_a & clk_b), 1);
      chk("R7 first rise stb", int'(stb_a & stb_b), 1);

      for (int i = 0; i < NV; i++) begin
         sel = 6'(VEC[i][0]);
         wait_stb();
         measure(h, ha, hb, hs);
         chk("R1 period", h / 2, VEC[i][1]);
         if (VEC[i][1] % 2 == 0) chk("R3 even duty", ha, VEC[i][1]);
         else                    chk("R4 LF half duty", ha, VEC[i][1]);
         chk("R5 HF duty", hb, VEC[i][2]);
         chk("R2/R6 err flag", int'(err_a), VEC[i][3]);
         chk("R10 strobe halves", hs, 2);
      end

      // R9: change made right after a rise lands one period later.
      sel = 6'd16;
      wait_stb(); wait_stb();
      sel = 6'd3;
      measure(h, ha, hb, hs);
      chk("R9 old period completes", h / 2, 16);
      measure(h, ha, hb, hs);
      chk("R9 new period applied", h / 2, 3);

      // R8: drop lock mid high phase, then relock.
      sel = 6'd16;
      wait_stb(); wait_stb();
      to_pos(); to_pos();
      chk("R8 high before drop", int'(clk_a & clk_b), 1);
      lock = 1'b0;
      #0.5;
      chk("R8 immediate low", int'(clk_a | clk_b), 0);
      to_pos();
      lock = 1'b1;
      to_pos();
      chk("R8 restart rise", int'(clk_a & stb_a), 1);
      measure(h, ha, hb, hs);
      chk("R8 fresh period", h / 2, 16);
      chk("R8 fresh high", ha, 16);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule